// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A tester drives a test clock, a mode-select line and a serial data input. The block walks a sixteen-state control machine on the rising clock edge. It holds a three-bit instruction, and it places one of three data paths between the serial input and the serial output. Those paths are a one-bit bypass stage, a 32-bit identification word, and an external boundary-cell chain. The boundary chain sits outside this block. Its serial output arrives on a port, and its capture, shift and update strobes leave on ports, together with a test-mode flag for the boundary cells.

After reset the identification word is selected, so a tester can read the chip's identity without loading an instruction. The serial output is registered on the falling clock edge. A separate enable tells the pad when the output is meaningful. All storage runs from the test clock and uses clock enables, with no gated clocks. The serial lines are bit-level control signals and have no back-pressure. Each clock edge moves exactly one bit, so there is no valid/ready handshake.

Top module: `scan_tap`

## Requirements
- R1: Driving `trst_n` low resets the controller at once, without waiting for a clock edge. While it is low, `tdo_oe` and `bsr_test_mode` are 0, and the active instruction is IDCODE (001).
- R2: Holding `tms` at 1 for five rising edges brings the controller to its reset state from any state. The reset state makes IDCODE the active instruction.
- R3: On entry to the instruction shift, the instruction shift register holds 001. The first three bits on `tdo` are therefore 1, 0, 0, least significant bit first.
- R4: With IDCODE active, a data shift presents the 32-bit word {version[3:0], part[15:0], maker[10:0], 1'b1}, least significant bit first.
- R5: With BYPASS (111) active, the first bit out of a data shift is 0. After that, `tdo` repeats `tdi` one clock later.
- R6: Opcodes 000, 010, 100 and 101 place the external chain between `tdi` and `tdo`, so `tdo` follows `bsr_so`. Only 000 and 100 raise `bsr_test_mode`.
- R7: The unused opcodes 011 and 110 behave as BYPASS.
- R8: `bsr_capture`, `bsr_shift` and `bsr_update` pulse only in the Capture-DR, Shift-DR and Update-DR states respectively, and only while an instruction from R6 is active.
- R9: A newly shifted instruction takes effect only when the controller passes Update-IR. Until then, the previous instruction's `bsr_test_mode` persists.
- R10: `tdo_oe` is 1 only in the Shift-IR and Shift-DR states, for example never in Pause-IR. Both `tdo_oe` and `tdo` change on the falling edge of `tck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select that steers the state machine |
| tdi | input | 1 | Serial data input |
| tdo | output | 1 | Serial data output, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for the `tdo` pad |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| bsr_capture | output | 1 | Boundary chain capture enable |
| bsr_shift | output | 1 | Boundary chain shift enable |
| bsr_update | output | 1 | Boundary chain update enable |
| bsr_test_mode | output | 1 | Boundary cells drive test values |

## Verification
The bench builds the block with version 4'hA, part 16'h5C3E and maker 11'h2B5. With these values every field of the identification word differs from its default, so a swapped or shifted field shows up in the 32 bits read out. The bench loads all eight opcodes in turn and reads two bits of data each time. Because `bsr_so` is held at 0 and the identification word ends in 1, the boundary chain, the identification word and the bypass stage each give a different pair of bits. Directed sequences then cover an asynchronous reset in the middle of a shift, the five-ones return to reset, and an instruction left pending in Pause-IR.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b010;
  localparam logic [IR_W-1:0] OP_INTEST  = 3'b100;
  localparam logic [IR_W-1:0] OP_STCTEST = 3'b101;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      TS_RESET:  return m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: return m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return m ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  return m ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: return m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: return m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: return m ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: return m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: return m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: return m ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  return m ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: return m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: return m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: return m ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: return m ? TS_SEL_DR : TS_IDLE;
      default:   return TS_RESET;
    endcase
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= tap_next(state, tms);
  end

  // R2
  reset_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET && tms) |=> (state == TS_RESET));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic            ir_so,
  output logic [IR_W-1:0] opcode
);
  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == TS_CAP_IR) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == TS_SH_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 opcode <= OP_IDCODE;
    else if (state == TS_RESET)  opcode <= OP_IDCODE;
    else if (state == TS_UPD_IR) opcode <= ir_sr;
  end

  assign ir_so = ir_sr[0];

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE));

  // R9
  opcode_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state != TS_UPD_IR && state != TS_RESET) |=> $stable(opcode));
endmodule

// File: rtl/tap_decode.sv
module tap_decode
  import scan_pkg::*;
(
  input  logic [IR_W-1:0] opcode,
  output logic            sel_bsr,
  output logic            sel_id,
  output logic            sel_byp,
  output logic            test_mode
);
  always_comb begin
    sel_bsr   = 1'b0;
    sel_id    = 1'b0;
    sel_byp   = 1'b0;
    test_mode = 1'b0;
    case (opcode)
      OP_EXTEST, OP_INTEST: begin
        sel_bsr   = 1'b1;
        test_mode = 1'b1;
      end
      OP_SAMPLE, OP_STCTEST: sel_bsr = 1'b1;
      OP_IDCODE:             sel_id  = 1'b1;
      default:               sel_byp = 1'b1;
    endcase
  end

  // R6
  always_comb begin
    one_path_chk: assert ($onehot({sel_bsr, sel_id, sel_byp}));
  end
endmodule

// File: rtl/tap_dreg.sv
module tap_dreg
  import scan_pkg::*;
#(
  parameter int          ID_W    = 32,
  parameter logic [31:0] ID_WORD = 32'h0000_0001
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  input  logic       sel_id,
  input  logic       sel_byp,
  output logic       id_so,
  output logic       byp_so
);
  logic [ID_W-1:0] id_sr;
  logic            byp_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= ID_WORD[ID_W-1:0];
    end else if (sel_id) begin
      if (state == TS_CAP_DR)     id_sr <= ID_WORD[ID_W-1:0];
      else if (state == TS_SH_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
    end else if (sel_byp) begin
      if (state == TS_CAP_DR)     byp_q <= 1'b0;
      else if (state == TS_SH_DR) byp_q <= tdi;
    end
  end

  assign id_so  = id_sr[0];
  assign byp_so = byp_q;

  // R5
  byp_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAP_DR && sel_byp) |=> (byp_q == 1'b0));

  // R4
  id_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_CAP_DR && sel_id) |=> (id_sr[0] == 1'b1));
endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'h0001,
  parameter logic [10:0] ID_MAKER   = 11'h001
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  input  logic bsr_so,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic bsr_test_mode
);
  localparam logic [31:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

  tap_state_e      state;
  logic [IR_W-1:0] opcode;
  logic            ir_so, id_so, byp_so;
  logic            sel_bsr, sel_id, sel_byp, test_mode;
  logic            ir_path, out_bit, shifting;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .ir_so(ir_so), .opcode(opcode)
  );

  tap_decode u_dec (
    .opcode(opcode), .sel_bsr(sel_bsr), .sel_id(sel_id),
    .sel_byp(sel_byp), .test_mode(test_mode)
  );

  tap_dreg #(.ID_W(32), .ID_WORD(ID_WORD)) u_dreg (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .sel_id(sel_id), .sel_byp(sel_byp), .id_so(id_so), .byp_so(byp_so)
  );

  always_comb begin
    case (state)
      TS_RESET, TS_IDLE, TS_SEL_IR, TS_CAP_IR, TS_SH_IR,
      TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR: ir_path = 1'b1;
      default:                                    ir_path = 1'b0;
    endcase
  end

  always_comb begin
    if (ir_path)      out_bit = ir_so;
    else if (sel_id)  out_bit = id_so;
    else if (sel_byp) out_bit = byp_so;
    else              out_bit = bsr_so;
  end

  assign shifting = (state == TS_SH_DR) || (state == TS_SH_IR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= out_bit;
      tdo_oe <= shifting;
    end
  end

  assign bsr_capture   = sel_bsr && (state == TS_CAP_DR);
  assign bsr_shift     = sel_bsr && (state == TS_SH_DR);
  assign bsr_update    = sel_bsr && (state == TS_UPD_DR);
  assign bsr_test_mode = test_mode;

  // R10
  oe_only_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == TS_SH_DR || state == TS_SH_IR));

  // R8
  strobe_excl_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  // R6
  test_mode_path_chk: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_test_mode |-> !(sel_id || sel_byp));
endmodule

// File: tb/scan_tap_tb.sv
module scan_tap_tb;
  localparam logic [31:0] EXP_ID = {4'hA, 16'h5C3E, 11'h2B5, 1'b1};
  // per opcode: {test_mode, kind}; kind 0 = boundary chain, 1 = id word, 2 = bypass
  localparam logic [2:0] EXP_TAB [8] = '{3'b100, 3'b001, 3'b000, 3'b010,
                                         3'b100, 3'b000, 3'b010, 3'b010};

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, bsr_so = 1'b0;
  logic tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update, bsr_test_mode;
  int n_tests = 0, n_fail = 0;
  logic s_tdo, s_oe, s_cap, s_sh, s_upd, s_tm;
  logic cap_seen, sh_seen, upd_seen;
  logic [31:0] dout;
  logic [2:0]  irout;

  scan_tap #(.ID_VERSION(4'hA), .ID_PART(16'h5C3E), .ID_MAKER(11'h2B5)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_so(bsr_so), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .bsr_test_mode(bsr_test_mode)
  );

  always #4 tck = ~tck;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(negedge tck); #1;
    s_tdo = tdo; s_oe = tdo_oe; s_cap = bsr_capture; s_sh = bsr_shift;
    s_upd = bsr_update; s_tm = bsr_test_mode;
    @(posedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] op);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i]);
      irout[i] = s_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din);
    cap_seen = 0; sh_seen = 0; upd_seen = 0; dout = '0;
    step(1, 0); step(0, 0);
    step(0, 0); cap_seen = s_cap;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = s_tdo;
      sh_seen = sh_seen | s_sh;
    end
    step(1, 0); step(0, 0); upd_seen = s_upd;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #10;
    chk("R1 reset oe", {31'b0, tdo_oe}, 0);
    chk("R1 reset test_mode", {31'b0, bsr_test_mode}, 0);
    @(posedge tck); #1; trst_n = 1'b1;
    step(1, 0); step(0, 0);

    // R4: identification word read right after reset
    shift_dr(32, 32'h0);
    chk("R4 idcode word", dout, EXP_ID);

    // R6 R7 R8 R3: every opcode from the table
    for (int op = 0; op < 8; op++) begin
      logic [1:0] kind;
      logic [1:0] exp2;
      kind = EXP_TAB[op][1:0];
      load_ir(3'(op));
      chk("R3 ir capture", {29'b0, irout}, 3'b001);
      chk("R6 test_mode", {31'b0, bsr_test_mode}, {31'b0, EXP_TAB[op][2]});
      bsr_so = 1'b0;
      shift_dr(2, 32'h1);
      exp2 = (kind == 0) ? 2'b00 : (kind == 1) ? EXP_ID[1:0] : 2'b10;
      chk((op == 3 || op == 6) ? "R7 unused->bypass" : "R6 path", {30'b0, dout[1:0]}, {30'b0, exp2});
      chk("R8 capture strobe", {31'b0, cap_seen}, {31'b0, kind == 0});
      chk("R8 shift strobe", {31'b0, sh_seen}, {31'b0, kind == 0});
      chk("R8 update strobe", {31'b0, upd_seen}, {31'b0, kind == 0});
    end

    // R6: boundary chain output reaches tdo
    load_ir(3'b101);
    bsr_so = 1'b1;
    shift_dr(3, 32'h0);
    chk("R6 bsr_so to tdo", {29'b0, dout[2:0]}, 3'b111);
    bsr_so = 1'b0;

    // R5: bypass delay with a pattern
    load_ir(3'b111);
    shift_dr(6, 32'b101101);
    chk("R5 bypass delay", {26'b0, dout[5:0]}, {26'b0, 6'b011010});

    // R9: pending instruction in Pause-IR
    load_ir(3'b000);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, 1); step(0, 1); step(1, 1);
    step(0, 0); step(0, 0);
    chk("R9 old mode held", {31'b0, s_tm}, 1);
    chk("R10 oe low in pause", {31'b0, s_oe}, 0);
    step(1, 0); step(1, 0); step(0, 0);
    chk("R9 new mode after update", {31'b0, bsr_test_mode}, 0);

    // R10: oe rises on the falling edge after entering Shift-DR
    step(1, 0); step(0, 0); step(0, 0);
    chk("R10 oe not at rising edge", {31'b0, tdo_oe}, 0);
    @(negedge tck); #1;
    chk("R10 oe after falling edge", {31'b0, tdo_oe}, 1);
    @(posedge tck); #1;
    step(1, 0); step(1, 0); step(0, 0);

    // R2: five ones from Shift-DR restore IDCODE
    load_ir(3'b111);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    shift_dr(32, 32'h0);
    chk("R2 five ones to reset", dout, EXP_ID);

    // R1: asynchronous reset mid-shift
    load_ir(3'b000);
    step(1, 0); step(0, 0); step(0, 0);
    #2; trst_n = 1'b0; #1;
    chk("R1 async test_mode", {31'b0, bsr_test_mode}, 0);
    chk("R1 async oe", {31'b0, tdo_oe}, 0);
    @(posedge tck); #1; trst_n = 1'b1;
    step(1, 0); step(0, 0);
    shift_dr(32, 32'h0);
    chk("R1 idcode after reset", dout, EXP_ID);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule